// File: doc/BRIEF.md
# Integer Execution Unit with Function-Code Decode

This block is the combinational integer datapath of a simple load/store RISC core. Each cycle the core hands it two 32-bit operand words, a 5-bit shift count and a 6-bit function code. The block returns a 32-bit result, an arithmetic-overflow flag for the trapping add and subtract, and a reserved-instruction flag when the function code is not one it implements.

Immediate-form instructions use the same datapath. A small expander widens the 16-bit immediate and can replace the second operand with it. The expander can sign-extend the immediate, zero-extend it, or place it in the upper half of the word. The core's decoder picks the expansion mode and a function code for the immediate opcode. Load-upper-immediate maps to OR with a zero first operand and the upper expansion.

Top module: `alu_core`

## Requirements
- R1: Function codes 0x20 and 0x21 return opb + opa modulo 2^32. Codes 0x22 and 0x23 return opa - opb modulo 2^32.
- R2: `ovf_o` is 1 only for code 0x20 or 0x22, and only when the true signed result falls outside the 32-bit two's-complement range. Codes 0x21 and 0x23, and every other code, give `ovf_o` = 0.
- R3: Code 0x24 returns opa AND opb. Code 0x25 returns opa OR opb. Code 0x27 returns NOT(opa OR opb).
- R4: Code 0x2A returns 1 if opa < opb as signed numbers, else 0. Code 0x2B returns 1 if opa < opb as unsigned magnitudes, else 0. Bits 31:1 of the result are always 0 for these codes.
- R5: Code 0x00 shifts opb left, code 0x02 shifts it right logically, and code 0x03 shifts it right arithmetically, each by `shamt_i`. A count of 0 returns opb unchanged.
- R6: Any function code not listed in R1 to R5 drives `rsvd_o` = 1, `result_o` = 0 and `ovf_o` = 0. The listed codes drive `rsvd_o` = 0.
- R7: With `imm_sel_i` = 1, the second operand is the expanded `imm_i`. `ext_mode_i` 2'b00 and 2'b11 sign-extend it from bit 15. 2'b01 zero-extends it.
- R8: `ext_mode_i` = 2'b10 places `imm_i` in bits 31:16 of the second operand and puts zeros in bits 15:0.
- R9: With `imm_sel_i` = 0, `imm_i` and `ext_mode_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (register form) |
| imm_i | input | 16 | Raw immediate field |
| imm_sel_i | input | 1 | 1: second operand comes from the expanded immediate |
| ext_mode_i | input | 2 | Immediate expansion: 00 sign, 01 zero, 10 upper half, 11 sign |
| shamt_i | input | 5 | Shift count |
| funct_i | input | 6 | Function code |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Arithmetic-overflow exception request |
| rsvd_o | output | 1 | Reserved-instruction flag |

## Verification
The block holds no state, so a wrong decode or a wrong internal selection shows on `result_o` or on one of the flags for the same input vector. There is no delay before it appears. A wrong carry or sign term in the adder shows up as a wrong overflow flag or a wrong set-less-than bit. Those errors appear mostly at the corner operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, so the sweep crosses every implemented code with those values. It also sweeps all 64 codes to catch a decode hole.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FW = 6;

  localparam logic [FW-1:0] F_SLL  = 6'h00;
  localparam logic [FW-1:0] F_SRL  = 6'h02;
  localparam logic [FW-1:0] F_SRA  = 6'h03;
  localparam logic [FW-1:0] F_ADD  = 6'h20;
  localparam logic [FW-1:0] F_ADDU = 6'h21;
  localparam logic [FW-1:0] F_SUB  = 6'h22;
  localparam logic [FW-1:0] F_SUBU = 6'h23;
  localparam logic [FW-1:0] F_AND  = 6'h24;
  localparam logic [FW-1:0] F_OR   = 6'h25;
  localparam logic [FW-1:0] F_NOR  = 6'h27;
  localparam logic [FW-1:0] F_SLT  = 6'h2A;
  localparam logic [FW-1:0] F_SLTU = 6'h2B;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'b00,
    EXT_ZERO  = 2'b01,
    EXT_UPPER = 2'b10,
    EXT_SIGN2 = 2'b11
  } ext_mode_e;

  typedef enum logic [3:0] {
    OP_SHL, OP_SHR, OP_ADD, OP_SUB, OP_AND,
    OP_OR, OP_NOR, OP_SLT, OP_SLTU, OP_BAD
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    arith;   // arithmetic right shift
    logic    trap;    // overflow may raise exception
    logic    rsvd;
  } alu_ctl_t;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] imm_i,
  input  logic [1:0]    mode_i,
  output logic [W-1:0]  word_o
);
  localparam int PAD = W - IW;

  always_comb begin
    case (mode_i)
      EXT_ZERO:  word_o = {{PAD{1'b0}}, imm_i};
      EXT_UPPER: word_o = {imm_i, {PAD{1'b0}}};
      default:   word_o = {{PAD{imm_i[IW-1]}}, imm_i};
    endcase
  end

  always_comb begin
    if (mode_i == EXT_ZERO) begin
      assert_zero_ext_top_R7: assert (word_o[W-1:IW] == '0);
    end
    if (mode_i == EXT_UPPER) begin
      assert_upper_low_clear_R8: assert (word_o[PAD-1:0] == '0);
    end
  end
endmodule

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [FW-1:0] funct_i,
  output alu_ctl_t      ctl_o
);
  always_comb begin
    ctl_o = '{op: OP_BAD, arith: 1'b0, trap: 1'b0, rsvd: 1'b0};
    case (funct_i)
      F_SLL:  ctl_o.op = OP_SHL;
      F_SRL:  ctl_o.op = OP_SHR;
      F_SRA:  begin ctl_o.op = OP_SHR; ctl_o.arith = 1'b1; end
      F_ADD:  begin ctl_o.op = OP_ADD; ctl_o.trap = 1'b1; end
      F_ADDU: ctl_o.op = OP_ADD;
      F_SUB:  begin ctl_o.op = OP_SUB; ctl_o.trap = 1'b1; end
      F_SUBU: ctl_o.op = OP_SUB;
      F_AND:  ctl_o.op = OP_AND;
      F_OR:   ctl_o.op = OP_OR;
      F_NOR:  ctl_o.op = OP_NOR;
      F_SLT:  ctl_o.op = OP_SLT;
      F_SLTU: ctl_o.op = OP_SLTU;
      default: ctl_o.rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,   // signed overflow, unqualified
  output logic         lt_o,    // signed a < b (valid when sub_i)
  output logic         ltu_o    // unsigned a < b (valid when sub_i)
);
  logic [W-1:0] b_x;
  logic         carry;

  assign b_x            = sub_i ? ~b_i : b_i;
  assign {carry, sum_o} = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
  assign ovf_o          = (a_i[W-1] == b_x[W-1]) && (sum_o[W-1] != a_i[W-1]);
  assign lt_o           = sum_o[W-1] ^ ovf_o;
  assign ltu_o          = ~carry;

  always_comb begin
    if (sub_i && a_i == b_i) begin
      assert_self_sub_zero_R1: assert (sum_o == '0 && !ovf_o && !lt_o && !ltu_o);
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] stg [SW+1];
  logic [W-1:0] rev_in, rev_out;
  logic         fill;

  // left shift runs through the right shifter on bit-reversed data
  always_comb begin
    for (int i = 0; i < W; i++) begin
      rev_in[i]  = val_i[W-1-i];
      rev_out[i] = stg[SW][W-1-i];
    end
  end

  assign fill   = arith_i & ~left_i & val_i[W-1];
  assign stg[0] = left_i ? rev_in : val_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{SH{fill}}, stg[k][W-1:SH]} : stg[k];
  end

  assign res_o = left_i ? rev_out : stg[SW];

  always_comb begin
    if (amt_i == '0) begin
      assert_zero_shift_pass_R5: assert (res_o == val_i);
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic [IW-1:0] imm_i,
  input  logic          imm_sel_i,
  input  logic [1:0]    ext_mode_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [FW-1:0] funct_i,
  output logic [W-1:0]  result_o,
  output logic          ovf_o,
  output logic          rsvd_o
);
  alu_ctl_t     ctl;
  logic [W-1:0] imm_word, b_op, sum, shifted;
  logic         add_ovf, lt_s, lt_u;

  alu_decode u_dec (.funct_i(funct_i), .ctl_o(ctl));

  alu_imm_ext #(.W(W), .IW(IW)) u_imm (
    .imm_i(imm_i), .mode_i(ext_mode_i), .word_o(imm_word)
  );

  assign b_op = imm_sel_i ? imm_word : opb_i;

  alu_addsub #(.W(W)) u_as (
    .a_i(opa_i), .b_i(b_op), .sub_i(ctl.op != OP_ADD),
    .sum_o(sum), .ovf_o(add_ovf), .lt_o(lt_s), .ltu_o(lt_u)
  );

  alu_shift #(.W(W), .SW(SW)) u_sh (
    .val_i(b_op), .amt_i(shamt_i), .left_i(ctl.op == OP_SHL),
    .arith_i(ctl.arith), .res_o(shifted)
  );

  always_comb begin
    case (ctl.op)
      OP_SHL, OP_SHR: result_o = shifted;
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = opa_i & b_op;
      OP_OR:          result_o = opa_i | b_op;
      OP_NOR:         result_o = ~(opa_i | b_op);
      OP_SLT:         result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:        result_o = {{(W-1){1'b0}}, lt_u};
      default:        result_o = '0;
    endcase
  end

  assign ovf_o  = ctl.trap & add_ovf;
  assign rsvd_o = ctl.rsvd;

  always_comb begin
    if (rsvd_o) begin
      assert_rsvd_quiet_R6: assert (result_o == '0 && !ovf_o);
    end
    if (ovf_o) begin
      assert_no_overflow_R2: assert (funct_i == F_ADD || funct_i == F_SUB);
    end
    if (funct_i == F_SLT || funct_i == F_SLTU) begin
      assert_slt_boolean_R4: assert (result_o[W-1:1] == '0 && !rsvd_o);
    end
  end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic [31:0] opa, opb, res;
  logic [15:0] imm;
  logic        imm_sel, ovf, rsvd;
  logic [1:0]  ext_mode;
  logic [4:0]  shamt;
  logic [5:0]  funct;
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu_core u0 (
    .opa_i(opa), .opb_i(opb), .imm_i(imm), .imm_sel_i(imm_sel),
    .ext_mode_i(ext_mode), .shamt_i(shamt), .funct_i(funct),
    .result_o(res), .ovf_o(ovf), .rsvd_o(rsvd)
  );

  localparam int NF = 12;
  logic [5:0] codes [NF] = '{6'h00, 6'h02, 6'h03, 6'h20, 6'h21, 6'h22,
                             6'h23, 6'h24, 6'h25, 6'h27, 6'h2A, 6'h2B};
  logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  function automatic string req_of(input logic [5:0] f);
    case (f)
      6'h20, 6'h22: return "R1/R2";
      6'h21, 6'h23: return "R1";
      6'h24, 6'h25, 6'h27: return "R3";
      6'h2A, 6'h2B: return "R4";
      6'h00, 6'h02, 6'h03: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic model(input logic [31:0] a, b, input logic [4:0] s, input logic [5:0] f,
                       output logic [31:0] r, output logic v, output logic x);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint t;
    r = 0; v = 0; x = 0;
    case (f)
      6'h20: begin t = sa + sb; r = a + b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      6'h21: r = a + b;
      6'h22: begin t = sa - sb; r = a - b; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      6'h23: r = a - b;
      6'h24: r = a & b;
      6'h25: r = a | b;
      6'h27: r = ~(a | b);
      6'h2A: r = (sa < sb) ? 32'd1 : 32'd0;
      6'h2B: r = ({32'h0, a} < {32'h0, b}) ? 32'd1 : 32'd0;
      6'h00: r = b << s;
      6'h02: r = b >> s;
      6'h03: r = 32'($signed(b) >>> s);
      default: x = 1;
    endcase
  endtask

  task automatic apply(input logic [31:0] a, b, input logic [4:0] s, input logic [5:0] f,
                       input logic [31:0] bref, input string tag);
    logic [31:0] er; logic ev, ex;
    @(negedge clk);
    opa = a; opb = b; shamt = s; funct = f;
    #5;
    model(a, bref, s, f, er, ev, ex);
    n_vec++;
    if (res !== er || ovf !== ev || rsvd !== ex) begin
      n_bad++;
      $display("FAIL %s funct=%h a=%h b=%h sh=%0d: got res=%h ovf=%b rsvd=%b exp res=%h ovf=%b rsvd=%b",
               tag, f, a, bref, s, res, ovf, rsvd, er, ev, ex);
    end
  endtask

  initial begin
    #(20 * 190000);
    $display("FAIL watchdog expired");
    n_bad++;
    done = 1;
  end

  initial begin
    logic [31:0] ra, rb, iw;
    logic [15:0] imv [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    opa = 0; opb = 0; imm = 0; imm_sel = 0; ext_mode = 0; shamt = 0; funct = 0;
    #5;
    // idle vector: all-zero inputs select a zero-count left shift of zero (R5)
    apply(0, 0, 0, 6'h00, 0, "R5 idle");

    // R1 R2 R3 R4 R5: corner operand cross product for every implemented code
    for (int f = 0; f < NF; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 4; k++) begin
            logic [4:0] s;
            s = (k == 0) ? 5'd0 : (k == 1) ? 5'd1 : (k == 2) ? 5'd31 : 5'd17;
            apply(corner[i], corner[j], s, codes[f], corner[j], req_of(codes[f]));
          end

    // random operands across all implemented codes
    for (int n = 0; n < 3000; n++) begin
      ra = $urandom; rb = $urandom;
      for (int f = 0; f < NF; f++)
        apply(ra, rb, 5'($urandom), codes[f], rb, req_of(codes[f]));
    end

    // R6: every one of the 64 codes
    for (int f = 0; f < 64; f++)
      for (int i = 0; i < 5; i++)
        apply(corner[i], corner[4 - i], 5'd3, 6'(f), corner[4 - i], req_of(6'(f)));

    // R7 R8: immediate expansion as second operand
    imm_sel = 1;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 5; i++) begin
        imm = imv[i];
        ext_mode = 2'(m);
        if (m == 1) iw = {16'h0, imv[i]};
        else if (m == 2) iw = {imv[i], 16'h0};
        else iw = {{16{imv[i][15]}}, imv[i]};
        for (int f = 0; f < NF; f++)
          for (int j = 0; j < 5; j++)
            apply(corner[j], 32'hDEADBEEF, 5'd4, codes[f], iw,
                  (m == 2) ? "R8" : "R7");
      end
    // R8: load-upper via OR with zero
    imm = 16'hA5C3; ext_mode = 2'b10;
    apply(0, 0, 0, 6'h25, 32'hA5C30000, "R8 lui");

    // R9: immediate inputs ignored when not selected
    imm_sel = 0;
    for (int n = 0; n < 500; n++) begin
      imm = 16'($urandom); ext_mode = 2'($urandom);
      ra = $urandom; rb = $urandom;
      for (int f = 0; f < NF; f++)
        apply(ra, rb, 5'($urandom), codes[f], rb, "R9");
    end

    done = 1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule